// File: doc/BRIEF.md
# Collision Backoff Delay Generator

This block times the pause a half-duplex Ethernet transmitter must take after a collision before it tries the frame again. The transmit controller gives it a single-cycle collision pulse together with the frame's retry count so far. In the same cycle the block takes a random number of slot times from a free-running pseudo-random register. It then holds a busy flag until that many slot times have passed. The transmit controller waits for the flag to fall before it starts the next attempt.

The random range follows truncated binary exponential backoff: the exponent is the retry count, capped at ten. A two-bit limit control can narrow the range further by capping the number of random bits used, which trades fairness under heavy contention for shorter waits. Slot time is counted in bit times through a bit-rate clock enable, so the block works at any ratio between the system clock and the line rate.

Top module: `coll_backoff_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy` is 0.
- R2: The exponent K is the retry count when that count is 10 or less, and 10 for any larger count.
- R3: The limit control sets a bit cap: 2'b00 gives 10, 2'b01 gives 8, 2'b10 gives 4, and 2'b11 gives 1. The wait uses min(K, cap) bits. With K=3 and the control at 2'b01, the wait therefore still uses 3 bits.
- R4: The random source is a 20-bit register. It is loaded with 20'h5A5A5 during reset and advances on every clock after reset as {s[18:0], s[19]^s[16]}. It never holds all zeros.
- R5: On a clock edge where `coll_pulse` is 1, the wait r is captured as the random register's value before that edge, ANDed with a mask of the low min(K, cap) bits. `busy` is 1 after that edge.
- R6: One slot time is SLOT_BITS clock cycles with `bit_en` high. The wait counts down one per slot time. `busy` stays 1 until the r*SLOT_BITS-th `bit_en` cycle after capture, and falls at the next clock edge.
- R7: When the captured r is 0, `busy` is 1 for exactly one cycle.
- R8: A collision pulse that arrives while `busy` is 1 discards the running wait and the partial slot. It captures afresh with the retry count and limit control present at that edge.
- R9: Cycles with `bit_en` low do not advance the wait. `busy` never rises without a collision pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| coll_pulse | input | 1 | One-cycle pulse marking a detected collision |
| retry_cnt | input | RETRY_W | Retries made so far for the current frame |
| limit_sel | input | 2 | Cap on the number of random bits used |
| bit_en | input | 1 | Clock enable, high once per line bit time |
| busy | output | 1 | High while the backoff wait is running |

## Verification
The assertions assume that `coll_pulse` is sampled only on the edge where it is high. They also assume that `retry_cnt` and `limit_sel` matter only in that cycle, and that `bit_en` may take any pattern. The stimulus drives each collision pulse for exactly one clock. Retry counts run from 0 to 15 and cover the region above the cap of ten. `bit_en` is a random pattern about three-quarters dense, with a hold-low stretch to show stalling. The bench shortens the slot length so that waits of up to 1023 slots stay within the run budget. Random trials at the widest cap use retry counts of at most eight. The full 10-bit width is exercised by directed cases.

// File: rtl/bo_pkg.sv
package bo_pkg;

  localparam int unsigned BO_K_CAP = 10;

  typedef enum logic [1:0] {
    CAP_WIDE  = 2'b00,
    CAP_MID   = 2'b01,
    CAP_SMALL = 2'b10,
    CAP_ONE   = 2'b11
  } bo_cap_e;

  // Exponent K: retry count saturated at the cap of ten.
  function automatic int unsigned bo_exponent(input logic [31:0] retries);
    return (retries > 32'(BO_K_CAP)) ? BO_K_CAP : int'(retries);
  endfunction

  // Bit cap chosen by the limit control.
  function automatic int unsigned bo_cap_bits(input logic [1:0] sel);
    int unsigned w;
    case (bo_cap_e'(sel))
      CAP_WIDE:  w = 10;
      CAP_MID:   w = 8;
      CAP_SMALL: w = 4;
      default:   w = 1;
    endcase
    return w;
  endfunction

  // Number of random bits that form the wait.
  function automatic int unsigned bo_used_bits(input logic [31:0] retries,
                                               input logic [1:0]  sel);
    int unsigned k;
    int unsigned c;
    k = bo_exponent(retries);
    c = bo_cap_bits(sel);
    return (k < c) ? k : c;
  endfunction

endpackage

// File: rtl/bo_lfsr.sv
module bo_lfsr #(
  parameter int unsigned      W     = 20,
  parameter logic [W-1:0]     TAPS  = 20'h90000,
  parameter logic [W-1:0]     SEED  = 20'h5A5A5
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);

  logic [W-1:0] q;
  logic [W-1:0] nxt;
  logic         fb;
  logic         lock_hit;

  always_comb begin
    fb       = ^(q & TAPS);
    nxt      = {q[W-2:0], fb};
    lock_hit = (nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= SEED;
    else if (lock_hit) q <= SEED;
    else               q <= nxt;
  end

  assign state = q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0); // R4
  AST_LFSR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> q[W-1:1] == $past(q[W-2:0])); // R4

endmodule

// File: rtl/bo_slot_prescaler.sv
module bo_slot_prescaler #(
  parameter int unsigned SLOT_BITS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic bit_en,
  output logic slot_tick
);

  localparam int unsigned PW = (SLOT_BITS > 2) ? $clog2(SLOT_BITS) : 1;
  localparam logic [PW-1:0] LAST = PW'(SLOT_BITS - 1);

  logic [PW-1:0] pre_q;
  logic          step;

  assign step      = run && bit_en;
  assign slot_tick = step && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre_q <= '0;
    else if (clr)       pre_q <= '0;
    else if (slot_tick) pre_q <= '0;
    else if (step)      pre_q <= pre_q + 1'b1;
  end

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pre_q) < SLOT_BITS); // R6
  AST_PRE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(pre_q)); // R9

endmodule

// File: rtl/bo_countdown.sv
module bo_countdown #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             slot_tick,
  output logic             busy,
  output logic             counting,
  output logic             expire
);

  logic [CNT_W-1:0] rem_q;
  logic             busy_q;
  logic             at_zero;

  assign at_zero  = (rem_q == '0);
  assign counting = busy_q && !at_zero && !load;
  assign expire   = busy_q && at_zero && !load;
  assign busy     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      rem_q  <= load_val;
      busy_q <= 1'b1;
    end else if (expire) begin
      busy_q <= 1'b0;
    end else if (counting && slot_tick) begin
      rem_q  <= rem_q - 1'b1;
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy_q && rem_q == $past(load_val)); // R5
  AST_ZERO_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && at_zero && !load) |=> !busy_q); // R7
  AST_TICK_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && slot_tick) |=> rem_q == $past(rem_q) - 1'b1); // R6
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !load && !slot_tick) |=> $stable(rem_q)); // R9
  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !load) |=> !busy_q); // R9

endmodule

// File: rtl/coll_backoff_gen.sv
module coll_backoff_gen
  import bo_pkg::*;
#(
  parameter int unsigned RETRY_W   = 5,
  parameter int unsigned LFSR_W    = 20,
  parameter int unsigned SLOT_BITS = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               coll_pulse,
  input  logic [RETRY_W-1:0] retry_cnt,
  input  logic [1:0]         limit_sel,
  input  logic               bit_en,
  output logic               busy
);

  localparam int unsigned CNT_W = BO_K_CAP;

  logic [LFSR_W-1:0] rnd;
  logic [CNT_W-1:0]  draw_mask;
  logic [CNT_W-1:0]  capt_val;
  int unsigned       used_bits;
  logic              slot_tick;
  logic              counting;
  logic              expire;

  bo_lfsr #(
    .W    (LFSR_W),
    .TAPS (LFSR_W'(20'h90000)),
    .SEED (LFSR_W'(20'h5A5A5))
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (rnd)
  );

  always_comb begin
    used_bits = bo_used_bits(32'(retry_cnt), limit_sel);
    for (int unsigned i = 0; i < CNT_W; i++) begin
      draw_mask[i] = (i < used_bits);
    end
    capt_val = rnd[CNT_W-1:0] & draw_mask;
  end

  bo_slot_prescaler #(
    .SLOT_BITS (SLOT_BITS)
  ) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (coll_pulse),
    .run       (counting),
    .bit_en    (bit_en),
    .slot_tick (slot_tick)
  );

  bo_countdown #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (coll_pulse),
    .load_val  (capt_val),
    .slot_tick (slot_tick),
    .busy      (busy),
    .counting  (counting),
    .expire    (expire)
  );

  AST_DRAW_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    coll_pulse |-> (32'(capt_val) >> used_bits) == 0); // R3
  AST_CAP_K_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    coll_pulse |-> used_bits <= 32'(retry_cnt)); // R2
  AST_COLL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    coll_pulse |=> busy); // R8
  AST_EXPIRE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !busy); // R6

endmodule

// File: tb/coll_backoff_gen_bench.sv
module coll_backoff_gen_bench;

  localparam int unsigned SLOT = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       coll_pulse = 1'b0;
  logic [4:0] retry_cnt = '0;
  logic [1:0] limit_sel = '0;
  logic       bit_en = 1'b0;
  logic       busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  coll_backoff_gen #(
    .RETRY_W   (5),
    .LFSR_W    (20),
    .SLOT_BITS (SLOT)
  ) u_coll_backoff_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .coll_pulse (coll_pulse),
    .retry_cnt  (retry_cnt),
    .limit_sel  (limit_sel),
    .bit_en     (bit_en),
    .busy       (busy)
  );

  // Random source model built from the R4 statement.
  logic [19:0] model_q;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_q <= 20'h5A5A5;
    else        model_q <= {model_q[18:0], model_q[19] ^ model_q[16]};
  end

  function automatic int width_for(input int retry, input int sel);
    int k;
    int cap;
    k = (retry >= 10) ? 10 : retry;
    if (sel == 0)      cap = 10;
    else if (sel == 1) cap = 8;
    else if (sel == 2) cap = 4;
    else               cap = 1;
    return (cap < k) ? cap : k;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Fires a collision and follows the wait to its end.
  task automatic run_backoff(input int retry, input int sel, input string tag);
    int w;
    int r;
    int target;
    int events;
    bit early;
    @(negedge clk);
    retry_cnt  = 5'(retry);
    limit_sel  = 2'(sel);
    coll_pulse = 1'b1;
    w = width_for(retry, sel);
    r = int'(model_q[9:0]) & ((1 << w) - 1);
    target = r * SLOT;
    @(posedge clk);
    @(negedge clk);
    coll_pulse = 1'b0;
    chk(busy == 1'b1, {tag, " R5 busy after capture"}, int'(busy), 1);
    events = 0;
    early  = 1'b0;
    while (events < target) begin
      bit_en = ($urandom % 4) != 0;
      @(posedge clk);
      if (bit_en) events++;
      @(negedge clk);
      if (!busy) early = 1'b1;
    end
    bit_en = 1'b0;
    chk(!early && busy, {tag, " R6 busy held for whole wait"}, int'(busy), 1);
    @(posedge clk);
    @(negedge clk);
    if (r == 0) chk(busy == 1'b0, {tag, " R7 zero wait ends in one cycle"}, int'(busy), 0);
    else        chk(busy == 1'b0, {tag, " R6 busy falls after last slot"}, int'(busy), 0);
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int rr;
    int ss;
    int w2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

    // R9: idle bit enables do not start a wait.
    bit_en = 1'b1;
    repeat (20) @(negedge clk);
    bit_en = 1'b0;
    chk(busy == 1'b0, "R9 idle stays low", int'(busy), 0);

    run_backoff(0, 0, "R2 retry zero");
    run_backoff(3, 1, "R3 K3 cap8");
    run_backoff(12, 0, "R2 retry12 cap10");
    run_backoff(12, 2, "R3 cap4");
    run_backoff(15, 3, "R3 cap1");
    run_backoff(9, 1, "R3 K9 cap8");
    run_backoff(10, 0, "R4 wide draw");

    // R9 stall and R8 restart.
    @(negedge clk);
    retry_cnt  = 5'd10;
    limit_sel  = 2'd0;
    coll_pulse = 1'b1;
    w2 = int'(model_q[9:0]);
    @(negedge clk);
    coll_pulse = 1'b0;
    repeat (40) @(negedge clk);
    chk(busy == (w2 != 0), "R9 no advance without bit_en", int'(busy), int'(w2 != 0));
    bit_en = 1'b1;
    repeat (5) @(negedge clk);
    bit_en = 1'b0;
    run_backoff(2, 0, "R8 restart");

    for (int t = 0; t < 40; t++) begin
      ss = int'($urandom % 4);
      rr = int'($urandom % 16);
      if (ss == 0 && rr > 8) rr = 8;
      run_backoff(rr, ss, "R5 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    finished = 1'b1;
    $finish;
  end

endmodule